// File: doc/BRIEF.md
# Stationary-Result Systolic Convolver

This block computes a running finite convolution `y_r = w1*x_r + w2*x_(r+1) + ... + wK*x_(r+K-1)` on a linear chain of K cells. Each cell holds one accumulator. That accumulator stays with the cell while the cell builds a single result. Samples enter at the left end and move one cell to the right on each clock. Weights enter at the right end and move one cell to the left on each clock. A weight sequencer sits at the right end and replays w1..wK from a small register set without pause. It marks w1 with a tag. Samples are spaced two cycles apart, and so are weights, so every sample meets every weight. When a sample and a weight share a cell, their product is added to that cell's accumulator.

When a tagged weight reaches a cell, the cell pushes its finished sum onto a registered output chain that runs to the right. The accumulator then restarts with the current product. The output chain never needs a shared bus, and results leave the right end in increasing index order. At any moment only about half of the cells are multiplying. This cost buys the absence of any broadcast wire.

The block is free running. A user loads the weights, usually while reset is held, and then streams samples. A sample is offered in any cycle where `smp_slot` is high.

Top module: `systolic_conv`

## Requirements
- R1: `smp_slot` is low in the first cycle after reset and then toggles on every cycle. A sample is captured at the rising edge that ends a cycle in which both `smp_slot` and `smp_valid` are high. `smp_valid` and `smp_data` are ignored in every cycle where `smp_slot` is low. Captured-slot number n counts the cycles with `smp_slot` high since reset, starting from 0.
- R2: The n-th valid result since reset, counting from 0, equals y_r with r = n - K + 1 + floor((K-1)/2), using y_r = sum over m=1..K of w_m * x_(r+m-1). Here x_i is the sample captured in slot i. It is taken as 0 if i < 0 or if slot i was offered with `smp_valid` low.
- R3: Samples, weights and results are two's complement signed values. Results are exact with DW+WW+clog2(K) bits, including the case where every operand is the most negative value.
- R4: Results leave in increasing r order. `res_valid` is never high on two consecutive cycles. Once it has gone high, it is high on every second cycle until the next reset.
- R5: The first valid result appears after the (2K + 2 + (K mod 2))-th rising edge that follows reset release.
- R6: Writing `wt_val` with `wt_we` at index `wt_sel` = i sets weight w_(i+1). Index 0 is w1, which is the tagged start of each pass. Writes take effect during reset, and reset leaves the stored weights unchanged.
- R7: While reset is held, `res_valid` and `smp_slot` are low.
- R8: A cell adds at most K products between two tags. On a tag it emits its sum and restarts, so no partial sum carries over into the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wt_we | input | 1 | Weight register write enable |
| wt_sel | input | clog2(K) | Weight index (0 selects w1) |
| wt_val | input | WW | Signed weight value |
| smp_valid | input | 1 | Sample present in this slot |
| smp_data | input | DW | Signed sample value |
| smp_slot | output | 1 | High when this cycle's sample inputs are captured |
| res_valid | output | 1 | Result valid |
| res_data | output | DW+WW+clog2(K) | Signed convolution result |

## Verification
The in-cell assertions assume one thing: the sample stream and the weight stream keep their fixed relative phase. That phase is set by the slot toggle and by the parity the sequencer derives from K. Given that, a cell sees at most K products per pass, and an emitted sum never lands on an occupied output stage. The assertions also assume the weights stay constant while a run is in progress. For that reason the stimulus rewrites weights only while reset is held. It drives inputs on the falling edge, offers samples only in response to `smp_slot`, and deliberately drives off-slot junk and in-slot gaps to test R1 and the zero treatment in R2.

// File: rtl/sysconv_pkg.sv
package sysconv_pkg;
  // accumulator width: exact sum of K signed products
  function automatic int acc_bits(int dw, int ww, int k);
    return dw + ww + $clog2(k);
  endfunction

  // phase of the slot toggle on which weights are launched; it makes
  // samples and weights coincide in every cell for either parity of K
  function automatic int wt_phase(int k);
    return k % 2;
  endfunction
endpackage

// File: rtl/sysconv_wseq.sv
module sysconv_wseq #(
  parameter int K  = 4,
  parameter int WW = 8,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic signed [WW-1:0] wr_data,
  output logic                 w_vld,
  output logic                 w_tag,
  output logic signed [WW-1:0] w_data
);
  localparam logic [IW-1:0] LAST = IW'(K - 1);

  // small register file, no reset so it maps onto distributed RAM
  logic signed [WW-1:0] wmem [K];
  logic [IW-1:0]        idx;

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < K)) wmem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        idx <= '0;
    else if (issue) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  assign w_vld  = issue;
  assign w_tag  = issue && (idx == '0);
  assign w_data = wmem[idx];
endmodule

// File: rtl/sysconv_cell.sv
module sysconv_cell #(
  parameter int K  = 4,
  parameter int DW = 8,
  parameter int WW = 8,
  parameter int AW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 x_vld_i,
  input  logic signed [DW-1:0] x_i,
  input  logic                 w_vld_i,
  input  logic                 w_tag_i,
  input  logic signed [WW-1:0] w_i,
  input  logic                 y_vld_i,
  input  logic signed [AW-1:0] y_i,
  output logic                 x_vld_o,
  output logic signed [DW-1:0] x_o,
  output logic                 w_vld_o,
  output logic                 w_tag_o,
  output logic signed [WW-1:0] w_o,
  output logic                 y_vld_o,
  output logic signed [AW-1:0] y_o
);
  localparam int PW = DW + WW;
  localparam int TW = $clog2(K + 2) + 1;

  logic signed [AW-1:0] acc;
  logic                 primed;
  logic                 meet, dump;
  logic signed [PW-1:0] prod;

  assign meet = x_vld_o && w_vld_o;
  assign dump = w_vld_o && w_tag_o;
  assign prod = PW'(x_o) * PW'(w_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_vld_o <= 1'b0;  x_o <= '0;
      w_vld_o <= 1'b0;  w_tag_o <= 1'b0;  w_o <= '0;
      y_vld_o <= 1'b0;  y_o <= '0;
      acc     <= '0;    primed <= 1'b0;
    end else begin
      // sample stream moves right, weight stream moves left
      x_vld_o <= x_vld_i;
      x_o     <= x_i;
      w_vld_o <= w_vld_i;
      w_tag_o <= w_tag_i;
      w_o     <= w_i;
      if (dump) begin
        // tagged w1: hand the finished sum to the output chain, restart
        y_vld_o <= primed;
        y_o     <= acc;
        primed  <= 1'b1;
        acc     <= meet ? AW'(prod) : '0;
      end else begin
        y_vld_o <= y_vld_i;
        y_o     <= y_i;
        if (meet) acc <= acc + AW'(prod);
      end
    end
  end

  // products collected since the last tag (checking aid only)
  logic [TW-1:0] terms;
  always_ff @(posedge clk) begin
    if (rst)       terms <= '0;
    else if (dump) terms <= meet ? TW'(1) : '0;
    else if (meet) terms <= terms + 1'b1;
  end

  assert_cell_terms_R8: assert property (@(posedge clk) disable iff (rst)
    terms <= TW'(K))
    else $error("cell collected more than K products");

  assert_no_collision_R4: assert property (@(posedge clk) disable iff (rst)
    dump |-> !y_vld_i)
    else $error("emitted sum met an occupied output stage");

  assert_x_gap_R1: assert property (@(posedge clk) disable iff (rst)
    x_vld_o |=> !x_vld_o)
    else $error("samples closer than two cycles");

  assert_w_gap_R8: assert property (@(posedge clk) disable iff (rst)
    w_vld_o |=> !w_vld_o)
    else $error("weights closer than two cycles");
endmodule

// File: rtl/systolic_conv.sv
module systolic_conv #(
  parameter  int K  = 4,
  parameter  int DW = 8,
  parameter  int WW = 8,
  localparam int IW = $clog2(K),
  localparam int AW = sysconv_pkg::acc_bits(DW, WW, K)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wt_we,
  input  logic [IW-1:0]        wt_sel,
  input  logic signed [WW-1:0] wt_val,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  output logic                 smp_slot,
  output logic                 res_valid,
  output logic signed [AW-1:0] res_data
);
  localparam logic WPH = 1'(sysconv_pkg::wt_phase(K));

  logic ph;
  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end
  assign smp_slot = ph;

  // stage arrays: sample/result index j feeds cell j; weight index j+1 feeds cell j
  logic                 xv [K+1];
  logic signed [DW-1:0] xd [K+1];
  logic                 wv [K+1];
  logic                 wt [K+1];
  logic signed [WW-1:0] wd [K+1];
  logic                 yv [K+1];
  logic signed [AW-1:0] yd [K+1];

  assign xv[0] = smp_valid && ph;
  assign xd[0] = smp_data;
  assign yv[0] = 1'b0;
  assign yd[0] = '0;

  sysconv_wseq #(.K(K), .WW(WW), .IW(IW)) u_wseq (
    .clk(clk), .rst(rst), .issue(ph == WPH),
    .wr_en(wt_we), .wr_idx(wt_sel), .wr_data(wt_val),
    .w_vld(wv[K]), .w_tag(wt[K]), .w_data(wd[K])
  );

  for (genvar j = 0; j < K; j++) begin : g_cell
    sysconv_cell #(.K(K), .DW(DW), .WW(WW), .AW(AW)) u_cell (
      .clk(clk), .rst(rst),
      .x_vld_i(xv[j]),   .x_i(xd[j]),
      .w_vld_i(wv[j+1]), .w_tag_i(wt[j+1]), .w_i(wd[j+1]),
      .y_vld_i(yv[j]),   .y_i(yd[j]),
      .x_vld_o(xv[j+1]), .x_o(xd[j+1]),
      .w_vld_o(wv[j]),   .w_tag_o(wt[j]),   .w_o(wd[j]),
      .y_vld_o(yv[j+1]), .y_o(yd[j+1])
    );
  end

  assign res_valid = yv[K];
  assign res_data  = yd[K];

  logic unused_ends;
  assign unused_ends = ^{xv[K], xd[K], wv[0], wt[0], wd[0]};

  assert_res_cadence_R4: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid)
    else $error("results on consecutive cycles");
endmodule

// File: tb/systolic_conv_tb_top.sv
`timescale 1ns/1ps
module systolic_conv_tb_top;
  localparam int K  = 4;
  localparam int DW = 4;
  localparam int WW = 4;
  localparam int IW = 2;
  localparam int AW = DW + WW + 2;
  localparam int R0    = (K - 1) / 2 - K + 1;
  localparam int FIRST = 2 * K + 2 + K % 2;
  localparam int RUN   = 150;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic                 wt_we = 1'b0;
  logic [IW-1:0]        wt_sel = '0;
  logic signed [WW-1:0] wt_val = '0;
  logic                 smp_valid = 1'b0;
  logic signed [DW-1:0] smp_data = '0;
  logic                 smp_slot, res_valid;
  logic signed [AW-1:0] res_data;

  systolic_conv #(.K(K), .DW(DW), .WW(WW)) dut_i (
    .clk(clk), .rst(rst), .wt_we(wt_we), .wt_sel(wt_sel), .wt_val(wt_val),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_slot(smp_slot),
    .res_valid(res_valid), .res_data(res_data)
  );

  int checks = 0, fails = 0;
  int wts [K];
  int xs [64];
  bit xv [64];
  int nsamp;
  bit junk;

  function automatic int xval(int n);
    if (n < 0 || n >= nsamp) return 0;
    if (!xv[n]) return 0;
    return xs[n];
  endfunction

  function automatic int model_y(int r);
    int s = 0;
    for (int m = 0; m < K; m++) s += wts[m] * xval(r + m);
    return s;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(string req, bit reload);
    int si = 0, nout = 0, first = -1, last = 0, expv;
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0;
    if (reload) begin
      // R6: weights written while reset is held
      for (int k = 0; k < K; k++) begin
        @(negedge clk);
        wt_we = 1'b1; wt_sel = IW'(k); wt_val = WW'(wts[k]);
      end
      @(negedge clk); wt_we = 1'b0;
    end else repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R7", "res_valid in reset", int'(res_valid), 0);
    check(smp_slot == 1'b0, "R7", "smp_slot in reset", int'(smp_slot), 0);
    rst = 1'b0;
    check(smp_slot == 1'b0, "R1", "slot low first cycle", int'(smp_slot), 0);
    for (int cyc = 1; cyc <= RUN; cyc++) begin
      @(posedge clk); @(negedge clk);
      if (res_valid) begin
        if (first < 0) first = cyc;
        else check(cyc - last == 2, "R4", "result spacing", cyc - last, 2);
        last = cyc;
        expv = model_y(R0 + nout);
        // R2 R8: each result is a fresh sum of exactly its own K terms
        check(int'(res_data) == expv, req, $sformatf("y[%0d]", R0 + nout),
              int'(res_data), expv);
        nout++;
      end
      if (smp_slot) begin
        if (si < nsamp && xv[si]) begin
          smp_valid = 1'b1; smp_data = DW'(xs[si]);
        end else begin
          smp_valid = 1'b0; smp_data = DW'(si);
        end
        si++;
      end else begin
        smp_valid = junk;             // R1: off-slot junk must be ignored
        smp_data  = junk ? 4'sb0111 : 4'sb0000;
      end
    end
    smp_valid = 1'b0;
    check(first == FIRST, "R5", "first result edge", first, FIRST);
    check(nout == (RUN - FIRST) / 2 + 1, "R4", "result count", nout, (RUN - FIRST) / 2 + 1);
  endtask

  initial begin
    // R2: ramp through all sample codes
    wts = '{1, 2, 3, 4}; nsamp = 40; junk = 0;
    for (int n = 0; n < 64; n++) begin xs[n] = n % 16 - 8; xv[n] = 1; end
    run_case("R2", 1);
    // R3: extreme operands, both signs of product
    wts = '{-8, -8, -8, -8};
    for (int n = 0; n < 64; n++) xs[n] = (n < 20) ? -8 : 7;
    run_case("R3", 1);
    // R2: mixed-sign weights with a zero, scrambled sample sweep
    wts = '{3, -1, 0, 5}; nsamp = 48;
    for (int n = 0; n < 64; n++) xs[n] = (n * 7) % 16 - 8;
    run_case("R2", 1);
    // R1: gaps in slots and junk offered off-slot
    wts = '{2, -3, 1, -1}; nsamp = 40; junk = 1;
    for (int n = 0; n < 64; n++) begin xs[n] = (n * 5) % 16 - 8; xv[n] = (n % 3 != 1); end
    run_case("R1", 1);
    // R6: reset again without rewriting; stored weights must survive
    run_case("R6", 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule